// File: doc/BRIEF.md
# Quarter-Wave Direct Digital Sine Synthesizer

This block produces a stream of signed sine samples, one on every clock, to drive an external converter. A tuning word sets the output frequency. On each clock that word is added into a wide phase register. The upper bits of that register, plus an optional phase offset, select a point on the waveform.

Only one quarter of a period is held in a lookup table. The other three quarters are rebuilt in two ways. The address into the table is mirrored on the falling quarters. The sample is negated on the lower half of the period. A new tuning word is loaded with a one-cycle strobe. It takes effect at once and does not disturb the running phase, so the output never jumps in phase when the frequency changes.

Top module: `dds_quarter_sine`

## Requirements
- R1: On every clock that is not in reset, the phase register advances by the active tuning word. The sum wraps modulo 2^ACC_W, with ACC_W = 32 by default.
- R2: While the load strobe is high at a clock edge, that edge adds the tuning word present on the input and stores it as the active word. Without the strobe the stored word is kept. A load never clears the phase register.
- R3: The phase offset input is added modulo 2^ACC_W to the phase register value before the table index is taken. The phase register itself is not changed by the offset.
- R4: The table index p is the top IDX_W bits of that sum (10 by default). Bit IDX_W-2 of p selects mirrored addressing: the low IDX_W-2 bits are inverted. The magnitude is round(A*sin((pi/2)*(k+0.5)/2^(IDX_W-2))), where k is the table address and A = 2^(OUT_W-1)-1 (2047 for the default OUT_W = 12).
- R5: When bit IDX_W-1 of p is set, the sample is the two's-complement negation of the magnitude. Otherwise it is the magnitude itself. As a result, sample(p) = round(A*sin(2*pi*(p+0.5)/2^IDX_W)).
- R6: The sample for the phase register value held between edges n and n+1 appears on the output after edge n+3. It uses the offset value that is present at edge n+1.
- R7: A synchronous active-high reset clears the phase register, the stored tuning word and every pipeline stage. The output reads 0 on the clock after a reset edge.
- R8: A tuning word with no ones in the top IDX_W bits makes the same sample repeat over several consecutive clocks. For example, 2^18 holds each index for 16 clocks.
- R9: A tuning word of 2^(ACC_W-2), one quarter of full scale, gives an output that repeats exactly every 4 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_word_i | input | ACC_W | Tuning word, taken when the load strobe is high |
| freq_load_i | input | 1 | Load strobe for the tuning word |
| phase_off_i | input | ACC_W | Phase offset added before table addressing |
| sample_o | output | OUT_W | Signed sine sample, registered |

## Verification
The hardest situation to reach from the ports is a tuning-word change or an offset change while the pipeline still holds samples from the previous settings. Only an exact cycle-by-cycle model shows whether the phase stayed continuous and whether the latency of each path is right. The stimulus therefore loads new words at arbitrary points and changes the offset on every clock. It compares each output against a behavioural phase model that applies the latency of R6 through a queue. It also steps the phase downward with a word close to full scale, so the index passes through every quadrant boundary and through the wrap point.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;
  localparam real PI_R = 3.14159265358979323846;

  // Magnitude of table entry k for a quarter table of the given depth.
  // Half-step centring makes the mirrored quadrants exact.
  function automatic int quarter_mag(input int k, input int depth, input int amp);
    real ang;
    ang = PI_R * (real'(k) + 0.5) / (2.0 * real'(depth));
    return int'(real'(amp) * $sin(ang));
  endfunction
endpackage

// File: rtl/dds_phase_acc.sv
`timescale 1ns/1ps
module dds_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] word_i,
  input  logic             load_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [ACC_W-1:0] word_o
);
  logic [ACC_W-1:0] word_q, acc_q, step_w;

  // A strobed word is used on the same edge that stores it.
  assign step_w = load_i ? word_i : word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      acc_q  <= '0;
    end else begin
      word_q <= step_w;
      acc_q  <= acc_q + step_w;
    end
  end

  assign acc_o  = acc_q;
  assign word_o = word_q;
endmodule

// File: rtl/dds_quadrant_fold.sv
`timescale 1ns/1ps
module dds_quadrant_fold #(
  parameter int IDX_W = 10,
  localparam int TAB_AW = IDX_W - 2
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [TAB_AW-1:0] addr_o,
  output logic              neg_o
);
  logic mirror_w;
  assign mirror_w = idx_i[IDX_W-2];
  assign addr_o   = mirror_w ? ~idx_i[TAB_AW-1:0] : idx_i[TAB_AW-1:0];
  assign neg_o    = idx_i[IDX_W-1];
endmodule

// File: rtl/dds_quarter_rom.sv
`timescale 1ns/1ps
module dds_quarter_rom #(
  parameter int AW = 8,
  parameter int DW = 11,
  localparam int DEPTH = 1 << AW,
  localparam int AMP = (1 << DW) - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] data_q;

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      mem[k] = DW'(dds_pkg::quarter_mag(k, DEPTH, AMP));
    end
  end

  // Registered read; the output register reset maps onto block RAM.
  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else     data_q <= mem[addr_i];
  end

  assign data_o = data_q;
endmodule

// File: rtl/dds_quarter_sine.sv
`timescale 1ns/1ps
module dds_quarter_sine #(
  parameter int ACC_W = 32,
  parameter int IDX_W = 10,
  parameter int OUT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ACC_W-1:0]        freq_word_i,
  input  logic                    freq_load_i,
  input  logic [ACC_W-1:0]        phase_off_i,
  output logic signed [OUT_W-1:0] sample_o
);
  localparam int TAB_AW = IDX_W - 2;
  localparam int MAG_W  = OUT_W - 1;

  logic [ACC_W-1:0]  acc_w, fw_w, sum_w;
  logic [IDX_W-1:0]  idx_q;
  logic [TAB_AW-1:0] addr_w;
  logic              neg_w, neg_q2;
  logic [MAG_W-1:0]  mag_q;
  logic signed [OUT_W-1:0] pos_w, out_q;

  dds_phase_acc #(.ACC_W(ACC_W)) acc_i (
    .clk(clk), .rst(rst), .word_i(freq_word_i), .load_i(freq_load_i),
    .acc_o(acc_w), .word_o(fw_w)
  );

  // Stage 1: offset applied, index registered
  assign sum_w = acc_w + phase_off_i;
  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else     idx_q <= IDX_W'(sum_w >> (ACC_W - IDX_W));
  end

  dds_quadrant_fold #(.IDX_W(IDX_W)) fold_i (
    .idx_i(idx_q), .addr_o(addr_w), .neg_o(neg_w)
  );

  // Stage 2: table read, sign flag carried alongside
  dds_quarter_rom #(.AW(TAB_AW), .DW(MAG_W)) rom_i (
    .clk(clk), .rst(rst), .addr_i(addr_w), .data_o(mag_q)
  );

  always_ff @(posedge clk) begin
    if (rst) neg_q2 <= 1'b0;
    else     neg_q2 <= neg_w;
  end

  // Stage 3: sign restore, registered output
  assign pos_w = $signed({1'b0, mag_q});
  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= neg_q2 ? -pos_w : pos_w;
  end

  assign sample_o = out_q;
endmodule

// File: rtl/dds_quarter_sine_chk.sv
`timescale 1ns/1ps
module dds_quarter_sine_chk #(
  parameter int ACC_W = 32,
  parameter int OUT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             freq_load_i,
  input logic [ACC_W-1:0] freq_word_i,
  input logic [ACC_W-1:0] acc_w,
  input logic [ACC_W-1:0] fw_w,
  input logic             neg_q2,
  input logic [OUT_W-2:0] mag_q,
  input logic [OUT_W-1:0] sample_o
);
  // R1: phase advances by the stored word when no load is pending
  p_acc_step_r1: assert property (@(posedge clk) disable iff (rst)
    !freq_load_i |=> acc_w == $past(acc_w) + $past(fw_w));

  // R2: a strobed word becomes the stored word
  p_load_take_r2: assert property (@(posedge clk) disable iff (rst)
    freq_load_i |=> fw_w == $past(freq_word_i));

  // R2: without a strobe the stored word is kept
  p_word_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !freq_load_i |=> $stable(fw_w));

  // R5: lower half of the period yields a negative sample
  p_sign_neg_r5: assert property (@(posedge clk) disable iff (rst)
    (neg_q2 && mag_q != '0) |=> sample_o[OUT_W-1]);

  // R5: upper half of the period yields a non-negative sample
  p_sign_pos_r5: assert property (@(posedge clk) disable iff (rst)
    !neg_q2 |=> !sample_o[OUT_W-1]);

  // R7: output is zero after a reset edge
  p_reset_out_r7: assert property (@(posedge clk)
    rst |=> sample_o == '0);
endmodule

bind dds_quarter_sine dds_quarter_sine_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) chk_i (
  .clk(clk), .rst(rst), .freq_load_i(freq_load_i), .freq_word_i(freq_word_i),
  .acc_w(acc_w), .fw_w(fw_w), .neg_q2(neg_q2), .mag_q(mag_q), .sample_o(sample_o)
);

// File: tb/dds_quarter_sine_tb_top.sv
`timescale 1ns/1ps
module dds_quarter_sine_tb_top;
  localparam int ACC_W = 32;
  localparam int IDX_W = 10;
  localparam int OUT_W = 12;
  localparam longint unsigned MASK = (64'd1 << ACC_W) - 1;
  localparam real PI_R = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld = 1'b0;
  logic [ACC_W-1:0] fw = '0, off = '0;
  logic signed [OUT_W-1:0] smp;

  int vectors = 0, errs = 0;
  string tag = "R7";
  bit started = 0, done = 0;
  int expq[$];
  int exp_now = 0;
  longint unsigned macc = 0, mfw = 0;

  always #10 clk = ~clk;

  dds_quarter_sine #(.ACC_W(ACC_W), .IDX_W(IDX_W), .OUT_W(OUT_W)) dut_i (
    .clk(clk), .rst(rst), .freq_word_i(fw), .freq_load_i(ld),
    .phase_off_i(off), .sample_o(smp)
  );

  // Whole-period reference value for index p (R4, R5)
  function automatic int ref_sample(input int p);
    real s;
    int m;
    s = $sin(2.0 * PI_R * (real'(p) + 0.5) / real'(1 << IDX_W));
    if (s < 0.0) s = -s;
    m = int'(real'((1 << (OUT_W - 1)) - 1) * s);
    return (p >= (1 << (IDX_W - 1))) ? -m : m;
  endfunction

  // Behavioural model: phase value, then a queue for the R6 latency
  always @(posedge clk) begin
    longint unsigned eff;
    int p;
    started = 1;
    if (rst) begin
      macc = 0; mfw = 0;
      expq = '{0, ref_sample(0)};
      exp_now = 0;
    end else begin
      p = int'(((macc + longint'(off)) & MASK) >> (ACC_W - IDX_W));
      expq.push_back(ref_sample(p));
      eff = ld ? longint'(fw) : mfw;
      macc = (macc + eff) & MASK;
      mfw = eff;
      exp_now = expq.pop_front();
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      vectors++;
      if (int'(smp) != exp_now) begin
        errs++;
        $display("FAIL %s R6 t=%0t actual=%0d expected=%0d", tag, $time, smp, exp_now);
      end
    end
  end

  task automatic check(input string req, input bit ok, input int act, input int expv);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic load(input logic [ACC_W-1:0] w);
    fw = w; ld = 1'b1;
    @(negedge clk);
    ld = 1'b0; fw = $urandom;
  endtask

  initial begin
    int hist[16];
    int changes;
    repeat (3) @(negedge clk);
    check("R7 reset output", smp == 0, smp, 0);
    rst = 1'b0;

    // R9: quarter-scale word, period of 4 samples
    tag = "R9";
    load(32'h4000_0000);
    repeat (6) @(negedge clk);
    for (int i = 0; i < 12; i++) begin hist[i] = smp; @(negedge clk); end
    for (int i = 0; i < 8; i++)
      check("R9 period 4", hist[i] == hist[i+4], hist[i+4], hist[i]);
    check("R9 not constant", hist[0] != hist[1], hist[1], hist[0]);

    // R8: word below the index bits repeats samples
    tag = "R8";
    load(32'h0004_0000);
    repeat (5) @(negedge clk);
    changes = 0;
    for (int i = 0; i < 16; i++) begin
      hist[i] = smp;
      if (i > 0 && hist[i] != hist[i-1]) changes++;
      @(negedge clk);
    end
    check("R8 repeated sample", changes <= 1, changes, 1);

    // R2: reloads at arbitrary points, phase continuity
    tag = "R2";
    for (int j = 0; j < 40; j++) begin
      load($urandom);
      repeat (1 + ($urandom % 9)) @(negedge clk);
    end

    // R3: offset varied every clock
    tag = "R3";
    load(32'h0123_4567);
    for (int j = 0; j < 200; j++) begin off = $urandom; @(negedge clk); end
    off = '0;

    // R1: downward step through wrap and every quadrant
    tag = "R1";
    load(32'hFFC0_0000);
    repeat (1100) @(negedge clk);
    load(32'hFFFF_FFFF);
    repeat (50) @(negedge clk);

    // R7: reset during operation
    tag = "R7";
    rst = 1'b1;
    @(negedge clk);
    check("R7 mid-run reset output", smp == 0, smp, 0);
    @(negedge clk);
    rst = 1'b0;
    tag = "R4";
    load(32'h0040_0000);
    repeat (1030) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule